// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Aggregator

This block collects interrupt events from a peripheral made of several sub-units and presents them to a host as one level-sensitive interrupt line. Two event sources feed the top level directly: a watchdog, which cannot be masked, and an arbiter. Each of `NSUB` further sub-units raises up to `DW` distinct events. Every such sub-unit has its own local status register and its own per-bit local mask.

A top-level status register tells the host which source is requesting. A top-level mask register controls how each source reaches the line. The host reads and writes every register through a simple synchronous port. Status bits are cleared by the read that reports them.

A typical service routine runs as follows. The host reads the top status, then reads the local status of each flagged sub-unit. Finally it rewrites the top mask. Writing the top mask drops the interrupt line for one cycle, so an edge-triggered host controller sees a fresh edge if anything is still pending.

Top module: `hier_irq_ctrl`

## Requirements
- R1: A watchdog event sets top status bit 0 (address 0) and asserts `irq`. No mask bit affects it.
- R2: While top mask bit 1 (address 1) is set, an arbiter event sets neither top status bit 1 nor `irq`. With the bit clear, the event sets both.
- R3: Top mask bit 2+i gates only the interrupt line for sub-unit i. Top status bit 2+i still reports that sub-unit's pending events while it is masked.
- R4: An event on bit b of sub-unit i is hidden while bit b of that sub-unit's local mask (address 2+NSUB+i) is set. It does not show in the local status (address 2+i) or in the top status, and it does not assert `irq`.
- R5: A hidden event stays latched, and a local status read does not clear it. Clearing its local mask bit makes it visible in the local and top status and asserts `irq` at the same clock edge as the write.
- R6: A read of the top status returns its value and clears bits 0 and 1 only. A read of a local status clears its visible bits, and this clears top bit 2+i when none remain.
- R7: `irq` is a registered level that updates at the same clock edge as the status. It stays high while any source is pending and not gated, and it falls at the edge where the last such source is cleared.
- R8: A write to the top mask forces `irq` low for exactly the one cycle after the write edge. After that cycle, `irq` returns to the level implied by the pending sources.
- R9: When an event and a clearing read hit the same status bit in the same cycle, the bit stays set.
- R10: After reset, `irq` is 0 and every status and mask register reads 0. Mask registers read back the full value written. Read data is registered at the read edge and shows the value before any clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wdog_evt | input | 1 | Watchdog event pulse |
| arb_evt | input | 1 | Arbiter event pulse |
| sub_evt | input | NSUB*DW | Sub-unit event pulses; sub-unit i uses bits i*DW+DW-1 down to i*DW |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data, valid from the edge that samples `reg_rd` |
| irq | output | 1 | Level interrupt to the host, active high |

## Verification
Every status flag and `irq` change at the first rising edge that samples the stimulus. The bench therefore drives at falling edges and checks `irq` at the next falling edge. Read data is registered at the sampling edge. A monitor, a quarter period after each rising edge where `reg_rd` was high, pops the expected value that the driver queued and compares it. The forced-low window is checked at two falling edges in a row: low in the first, restored in the second.

// File: rtl/hier_irq_ctrl.sv
module hier_irq_ctrl #(
  parameter int NSUB = 3,
  parameter int DW   = 8,
  parameter int AW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdog_evt,
  input  logic               arb_evt,
  input  logic [NSUB*DW-1:0] sub_evt,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq
);
  localparam int A_TOP  = 0;
  localparam int A_TMSK = 1;
  localparam int A_LST  = 2;
  localparam int A_LMSK = 2 + NSUB;
  localparam int B_SUB  = 2;

  logic wd_q, arb_q, wd_n, arb_n;
  logic [DW-1:0] tm_q, tm_n;
  logic [DW-1:0] pend_q [NSUB];
  logic [DW-1:0] lm_q   [NSUB];
  logic [DW-1:0] pend_n [NSUB];
  logic [DW-1:0] lm_n   [NSUB];
  logic [NSUB-1:0] vis_q, vis_n;
  logic [DW-1:0] rd_val;
  logic irq_d;

  wire top_rd  = reg_rd && (reg_addr == AW'(A_TOP));
  wire tmsk_wr = reg_wr && (reg_addr == AW'(A_TMSK));

  assign wd_n  = wdog_evt | (wd_q & ~top_rd);
  assign arb_n = (arb_evt & ~tm_q[1]) | (arb_q & ~top_rd);
  assign tm_n  = tmsk_wr ? reg_wdata : tm_q;

  for (genvar i = 0; i < NSUB; i++) begin : g_sub
    wire lst_rd = reg_rd && (reg_addr == AW'(A_LST + i));
    wire lmk_wr = reg_wr && (reg_addr == AW'(A_LMSK + i));

    assign lm_n[i]   = lmk_wr ? reg_wdata : lm_q[i];
    assign pend_n[i] = (pend_q[i] & ~(lst_rd ? ~lm_q[i] : '0)) | sub_evt[i*DW +: DW];
    assign vis_n[i]  = |(pend_n[i] & ~lm_n[i]);
    assign vis_q[i]  = |(pend_q[i] & ~lm_q[i]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        pend_q[i] <= '0;
        lm_q[i]   <= '0;
      end else begin
        pend_q[i] <= pend_n[i];
        lm_q[i]   <= lm_n[i];
      end

    // R5: hidden events survive reads
    p_hidden_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
      |(pend_q[i] & lm_q[i]) |=>
        ((pend_q[i] & $past(pend_q[i] & lm_q[i])) == $past(pend_q[i] & lm_q[i])));
  end

  assign irq_d = ~tmsk_wr & (wd_n | arb_n | |(vis_n & ~tm_n[B_SUB +: NSUB]));

  always_comb begin
    rd_val = '0;
    if (reg_addr == AW'(A_TOP))
      rd_val[NSUB+1:0] = {vis_q, arb_q, wd_q};
    else if (reg_addr == AW'(A_TMSK))
      rd_val = tm_q;
    for (int i = 0; i < NSUB; i++) begin
      if (reg_addr == AW'(A_LST + i))  rd_val = pend_q[i] & ~lm_q[i];
      if (reg_addr == AW'(A_LMSK + i)) rd_val = lm_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_q      <= 1'b0;
      arb_q     <= 1'b0;
      tm_q      <= '0;
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      wd_q  <= wd_n;
      arb_q <= arb_n;
      tm_q  <= tm_n;
      irq   <= irq_d;
      if (reg_rd) reg_rdata <= rd_val;
    end

  p_wd_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_evt |=> wd_q);
  p_wd_irq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_evt && !tmsk_wr |=> irq);
  p_arb_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arb_evt && tm_q[1] && !arb_q |=> !arb_q);
  p_mask_wr_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tmsk_wr |=> !irq);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_evt && top_rd |=> wd_q);
endmodule

// File: tb/test_hier_irq_ctrl.sv
module test_hier_irq_ctrl;
  localparam time CLK_PERIOD = 10;
  localparam int NSUB = 3, DW = 8, AW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wdog_evt = 1'b0, arb_evt = 1'b0;
  logic [NSUB*DW-1:0] sub_evt = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic irq;

  typedef struct { logic [DW-1:0] exp; string tag; } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;

  hier_irq_ctrl #(.NSUB(NSUB), .DW(DW), .AW(AW)) i_hier_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wdog_evt(wdog_evt), .arb_evt(arb_evt),
    .sub_evt(sub_evt), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin : monitor
    logic fire;
    item_t it;
    forever begin
      @(posedge clk);
      fire = reg_rd;
      #(CLK_PERIOD/4);
      if (fire) begin
        if (sb.size() == 0) begin
          fails++;
          $display("FAIL unexpected read data %h expected none", reg_rdata);
        end else begin
          it = sb.pop_front();
          checks++;
          if (reg_rdata !== it.exp) begin
            fails++;
            $display("FAIL %s rdata actual=%h expected=%h", it.tag, reg_rdata, it.exp);
          end
        end
      end
    end
  end

  task automatic cyc(input logic wd, input logic ar, input logic [NSUB*DW-1:0] se,
                     input logic rd, input logic wr, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input logic [DW-1:0] exp, input string tag);
    wdog_evt = wd; arb_evt = ar; sub_evt = se;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    if (rd) sb.push_back('{exp, tag});
    @(negedge clk);
    wdog_evt = 0; arb_evt = 0; sub_evt = '0; reg_rd = 0; reg_wr = 0;
    reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    cyc(0, 0, '0, 1, 0, a, '0, exp, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(0, 0, '0, 0, 1, a, d, '0, "");
  endtask

  task automatic pulse(input logic wd, input logic ar, input logic [NSUB*DW-1:0] se);
    cyc(wd, ar, se, 0, 0, '0, '0, '0, "");
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (irq !== exp) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk_irq(0, "R10 reset irq");
    for (int a = 0; a < 2 + 2*NSUB; a++) rd(AW'(a), '0, "R10 reset reg");
    wr(4'd5, 8'hA5);
    rd(4'd5, 8'hA5, "R10 lmask readback");
    wr(4'd5, 8'h00);

    // R1 watchdog
    pulse(1, 0, '0);
    chk_irq(1, "R1 wdog irq");
    rd(4'd0, 8'h01, "R1 wdog flag");
    chk_irq(0, "R7 irq falls after service");
    rd(4'd0, 8'h00, "R6 top read cleared wdog");

    // R2 arbiter masked then unmasked
    wr(4'd1, 8'h02);
    pulse(0, 1, '0);
    chk_irq(0, "R2 arb masked irq");
    rd(4'd0, 8'h00, "R2 arb masked flag");
    wr(4'd1, 8'h00);
    pulse(0, 1, '0);
    chk_irq(1, "R2 arb unmasked irq");
    rd(4'd0, 8'h02, "R2 arb flag");
    chk_irq(0, "R6 arb cleared irq");

    // R3 sub top mask gates line only
    wr(4'd1, 8'h04);
    pulse(0, 0, 24'h000008);
    chk_irq(0, "R3 sub0 gated irq");
    rd(4'd0, 8'h04, "R3 sub0 flag while masked");
    rd(4'd2, 8'h08, "R3 sub0 local status");
    rd(4'd0, 8'h00, "R6 local read clears top bit");
    wr(4'd1, 8'h00);

    // R4 / R5 local mask hides and latches
    wr(4'd6, 8'h20);
    pulse(0, 0, 24'h002000);
    chk_irq(0, "R4 local masked irq");
    rd(4'd3, 8'h00, "R4 local masked status");
    rd(4'd0, 8'h00, "R4 local masked top");
    wr(4'd6, 8'h00);
    chk_irq(1, "R5 release irq");
    rd(4'd0, 8'h08, "R5 release top");
    rd(4'd3, 8'h20, "R5 release local");
    chk_irq(0, "R5 serviced irq");

    // R7 / R6 several sources
    pulse(1, 0, 24'h010000);
    chk_irq(1, "R7 two sources irq");
    rd(4'd0, 8'h11, "R7 two sources top");
    chk_irq(1, "R7 irq held while sub2 pending");
    rd(4'd0, 8'h10, "R6 top read keeps sub bit");
    rd(4'd4, 8'h01, "R6 sub2 local");
    chk_irq(0, "R7 all serviced");

    // R8 forced low on mask write
    pulse(0, 0, 24'h000002);
    chk_irq(1, "R8 pending before write");
    wr(4'd1, 8'h00);
    chk_irq(0, "R8 forced low");
    @(negedge clk);
    chk_irq(1, "R8 restored");
    rd(4'd2, 8'h02, "R8 sub0 local");
    chk_irq(0, "R8 serviced");

    // R9 set beats clear
    pulse(1, 0, '0);
    cyc(1, 0, '0, 1, 0, 4'd0, '0, 8'h01, "R9 top read with wdog");
    chk_irq(1, "R9 wdog kept irq");
    rd(4'd0, 8'h01, "R9 wdog kept flag");
    pulse(0, 0, 24'h000004);
    cyc(0, 0, 24'h000004, 1, 0, 4'd2, '0, 8'h04, "R9 local read with event");
    rd(4'd2, 8'h04, "R9 local bit kept");
    rd(4'd2, 8'h00, "R9 local cleared");
    chk_irq(0, "R9 final irq");

    @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule